// File: doc/BRIEF.md
# Randomised Slot-Order Arbiter

This block shares one resource among a set of cores, four by default. Time is cut into windows. Each window holds one slot per core, and each slot lasts a fixed number of cycles (two by default, so a window is eight cycles long). At every window boundary the order of the slots is reshuffled into a new random permutation of the core identifiers. Every core therefore gets exactly one slot per window, but its position inside the window cannot be predicted.

Arbitration is non-work-conserving. A core that requests outside its own slot waits, even if the resource is idle. The random bits come from an internal 16-bit linear feedback shift register. Software seeds this register before a run, so a given seed always replays the same sequence of permutations. A seed of zero is swapped for a fixed nonzero value. The shuffle for the next window is built step by step while the current window runs, so the new order is ready at the boundary without a dead cycle.

The permutation in force is exported as one field per slot, which lets a bench check every window.

The sequencer has two states:
- PH_PRIME to PH_RUN, on the last cycle of a window.
- Any state to PH_PRIME, on a seed load.

The shuffle engine has three states:
- SH_START to SH_SWAP, after the first swap.
- SH_SWAP to SH_READY, after the swap at index 1.
- Any state to SH_START, on a window end or a seed load.

Top module: `rp_slot_arbiter`

## Requirements
- R1: After reset, `perm_live` is 0, `grant` is all zeros, and `perm_obs` holds the identity order: slot s holds core s, so the value is 8'hE4.
- R2: While `perm_live` is 1, field s of `perm_obs` (bits [2s+1:2s]) names the core that owns slot s. Each core id appears exactly once. The value stays constant for the whole window.
- R3: `grant[c]` is 1 exactly when `req[c]` is 1, `perm_live` is 1, and core c owns the current slot. Slot s covers window cycles 2s and 2s+1. At most one grant is high at a time, and a core never receives a grant outside its own slot.
- R4: A seed load restarts the sequencer at window cycle 0 of a priming window. A priming window is the state after reset or after a seed load. It lasts 8 cycles, gives no grants and keeps `perm_live` at 0. `perm_live` rises on the first cycle of the next window.
- R5: When `seed_load` is sampled high, the generator register takes `seed_value`, or 16'hACE1 if `seed_value` is zero. The register is 16'hACE1 after reset and is never zero.
- R6: The generator advances once per clock: s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}. Loading the same seed twice replays the same sequence of permutations.
- R7: The next window's permutation is built by a shuffle that starts from the identity order. In window cycle k (k = 0 to 2), positions i = 3-k and j = s[7:0] mod (i+1) are swapped, where s is the generator value in that cycle. The result takes effect at the next window boundary.
- R8: A core that owns the last slot of one window and the first slot of the next is granted on four consecutive cycles while it keeps requesting.
- R9: Over enough windows, all 24 orderings of four cores occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_value` into the generator and restart with a priming window |
| seed_value | input | 16 | Seed for the random generator |
| req | input | 4 | Per-core request |
| grant | output | 4 | Per-core grant, at most one bit high |
| perm_obs | output | 8 | Slot-to-core order in force, 2 bits per slot, slot 0 in bits [1:0] |
| perm_live | output | 1 | High once a shuffled permutation governs the window |

## Verification
The bench tracks window boundaries where the same core owns the last slot and then the first slot. A design that delayed the new order by one cycle, or dropped the grant at the boundary, would break the four-cycle run or show a stale owner in the first slot. Seeds loaded in the middle of a window check the restart into priming; a design that kept its old cycle count or granted during priming would miscompare at once. Seeds of zero and 16'hACE1 must give identical sequences, and a repeated seed must replay exactly. Finally, the count of distinct orderings exposes a shuffle whose modulo reduction misses some of the 24 orders.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

    localparam int LFSR_W = 16;
    localparam int RND_W  = 8;
    localparam logic [LFSR_W-1:0] LFSR_ALT_SEED = 16'hACE1;

    typedef enum logic {
        PH_PRIME,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        SH_START,
        SH_SWAP,
        SH_READY
    } shuf_e;

    // taps 16,14,13,11: maximal length, never reaches zero from a nonzero state
    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/rpa_lfsr.sv
module rpa_lfsr
    import rpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed_value,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_d;

    always_comb begin
        if (seed_load)
            state_d = (seed_value == '0) ? LFSR_ALT_SEED : seed_value;
        else
            state_d = lfsr_advance(state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LFSR_ALT_SEED;
        else
            state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/rpa_shuffle.sv
module rpa_shuffle
    import rpa_pkg::*;
#(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic [RND_W-1:0]          rnd,
    output logic [N-1:0][ID_W-1:0]    next_perm
);

    shuf_e                  state_q, state_d;
    logic [ID_W-1:0]        step_q, step_d;
    logic [N-1:0][ID_W-1:0] work_q, work_d;

    logic [N-1:0][ID_W-1:0] base;
    logic [N-1:0][ID_W-1:0] swapped;
    logic [ID_W-1:0]        idx;
    logic [RND_W-1:0]       divisor;
    logic [RND_W-1:0]       draw;
    logic [ID_W-1:0]        pick;

    // one Fisher-Yates swap per cycle; SH_START begins from the identity order
    always_comb begin
        for (int i = 0; i < N; i++)
            base[i] = (state_q == SH_START) ? ID_W'(i) : work_q[i];
        idx     = (state_q == SH_START) ? ID_W'(N - 1) : step_q;
        divisor = RND_W'(idx) + RND_W'(1);
        draw    = rnd % divisor;
        pick    = draw[ID_W-1:0];
        swapped       = base;
        swapped[idx]  = base[pick];
        swapped[pick] = base[idx];
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        work_d  = work_q;
        if (restart) begin
            state_d = SH_START;
        end else begin
            unique case (state_q)
                SH_START: begin
                    work_d  = swapped;
                    step_d  = ID_W'(N - 2);
                    state_d = (N > 2) ? SH_SWAP : SH_READY;
                end
                SH_SWAP: begin
                    work_d = swapped;
                    step_d = step_q - ID_W'(1);
                    if (step_q == ID_W'(1))
                        state_d = SH_READY;
                end
                SH_READY: begin
                    state_d = SH_READY;
                end
                default: state_d = SH_START;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_START;
            step_q  <= '0;
            for (int i = 0; i < N; i++)
                work_q[i] <= ID_W'(i);
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            work_q  <= work_d;
        end
    end

    assign next_perm = work_q;

endmodule

// File: rtl/rpa_sequencer.sv
module rpa_sequencer
    import rpa_pkg::*;
#(
    parameter int N           = 4,
    parameter int ID_W        = 2,
    parameter int SLOT_CYCLES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seed_load,
    input  logic [N-1:0]           req,
    input  logic [N-1:0][ID_W-1:0] next_perm,
    output logic [N-1:0][ID_W-1:0] cur_perm,
    output logic [N-1:0]           grant,
    output logic                   live,
    output logic                   win_last
);

    localparam int WIN   = N * SLOT_CYCLES;
    localparam int CYC_W = (WIN > 1) ? $clog2(WIN) : 1;

    phase_e                 phase_q;
    logic [CYC_W-1:0]       cyc_q;
    logic [N-1:0][ID_W-1:0] cur_q;
    logic [ID_W-1:0]        slot;
    logic [ID_W-1:0]        owner;

    assign win_last = (cyc_q == CYC_W'(WIN - 1));
    assign slot     = ID_W'(cyc_q / CYC_W'(SLOT_CYCLES));
    assign owner    = cur_q[slot];

    // state register: phase, window cycle, order in force
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_PRIME;
            cyc_q   <= '0;
            for (int i = 0; i < N; i++)
                cur_q[i] <= ID_W'(i);
        end else if (seed_load) begin
            phase_q <= PH_PRIME;
            cyc_q   <= '0;
        end else if (win_last) begin
            phase_q <= PH_RUN;
            cyc_q   <= '0;
            cur_q   <= next_perm;
        end else begin
            cyc_q   <= cyc_q + CYC_W'(1);
        end
    end

    // outputs
    always_comb begin
        grant = '0;
        live  = 1'b0;
        unique case (phase_q)
            PH_PRIME: begin
                grant = '0;
                live  = 1'b0;
            end
            PH_RUN: begin
                live  = 1'b1;
                grant = req & (N'(1) << owner);
            end
            default: grant = '0;
        endcase
    end

    assign cur_perm = cur_q;

endmodule

// File: rtl/rp_slot_arbiter.sv
module rp_slot_arbiter
    import rpa_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int SLOT_CYCLES = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     seed_load,
    input  logic [LFSR_W-1:0]                        seed_value,
    input  logic [NUM_CORES-1:0]                     req,
    output logic [NUM_CORES-1:0]                     grant,
    output logic [NUM_CORES*$clog2(NUM_CORES)-1:0]   perm_obs,
    output logic                                     perm_live
);

    localparam int ID_W = $clog2(NUM_CORES);

    logic [LFSR_W-1:0]              lfsr_state;
    logic [NUM_CORES-1:0][ID_W-1:0] next_perm;
    logic [NUM_CORES-1:0][ID_W-1:0] cur_perm;
    logic                           win_last;

    rpa_lfsr u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .state      (lfsr_state)
    );

    rpa_shuffle #(
        .N    (NUM_CORES),
        .ID_W (ID_W)
    ) u_shuffle (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (seed_load | win_last),
        .rnd       (lfsr_state[RND_W-1:0]),
        .next_perm (next_perm)
    );

    rpa_sequencer #(
        .N           (NUM_CORES),
        .ID_W        (ID_W),
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .req       (req),
        .next_perm (next_perm),
        .cur_perm  (cur_perm),
        .grant     (grant),
        .live      (perm_live),
        .win_last  (win_last)
    );

    assign perm_obs = cur_perm;

endmodule

// File: rtl/rpa_checker.sv
module rpa_checker #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seed_load,
    input logic              win_last,
    input logic              perm_live,
    input logic [N-1:0]      req,
    input logic [N-1:0]      grant,
    input logic [N*ID_W-1:0] perm_obs,
    input logic [15:0]       lfsr_state
);

    logic perm_ok;
    int   hits;

    always_comb begin
        perm_ok = 1'b1;
        for (int id = 0; id < N; id++) begin
            hits = 0;
            for (int s = 0; s < N; s++)
                if (perm_obs[s*ID_W +: ID_W] == ID_W'(id))
                    hits++;
            if (hits != 1)
                perm_ok = 1'b0;
        end
    end

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    p_no_grant_prime_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !perm_live |-> grant == '0);

    p_live_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perm_live) |-> $past(win_last) && !$past(seed_load));

    p_perm_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        perm_live |-> perm_ok);

    p_perm_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_live && !win_last) |=> $stable(perm_obs));

    p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != 16'h0000);

endmodule

bind rp_slot_arbiter rpa_checker #(
    .N    (NUM_CORES),
    .ID_W (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .win_last   (win_last),
    .perm_live  (perm_live),
    .req        (req),
    .grant      (grant),
    .perm_obs   (perm_obs),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_rp_slot_arbiter.sv
`timescale 1ns/1ps
module tb_rp_slot_arbiter;

    localparam int N   = 4;
    localparam int SC  = 2;
    localparam int WIN = N * SC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_value = 16'h0;
    logic [3:0]  req = 4'h0;
    logic [3:0]  grant;
    logic [7:0]  perm_obs;
    logic        perm_live;

    always #2 clk = ~clk;

    rp_slot_arbiter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .req        (req),
        .grant      (grant),
        .perm_obs   (perm_obs),
        .perm_live  (perm_live)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference
    int m_lfsr = 16'hACE1;
    int m_cyc = 0;
    bit m_live = 0;
    int m_cur[4] = '{0, 1, 2, 3};
    int m_work[4] = '{0, 1, 2, 3};
    int m_prev_last = -1;

    bit          rec_on = 0;
    logic [7:0]  rec_q[$];
    logic [7:0]  rec_a[$];
    logic [7:0]  rec_b[$];
    bit          seen[256];
    int          b2b_seen = 0;

    function automatic int lfsr_step(int s);
        int fb;
        fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
        return ((s << 1) | fb) & 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 16'hACE1; m_cyc = 0; m_live = 0; m_prev_last = -1;
            m_cur = '{0, 1, 2, 3}; m_work = '{0, 1, 2, 3};
        end else if (seed_load) begin
            m_lfsr = (seed_value == 16'h0) ? 16'hACE1 : int'(seed_value);
            m_cyc = 0; m_live = 0; m_prev_last = -1;
        end else begin
            if (m_cyc < N - 1) begin
                int i, j, t;
                if (m_cyc == 0) m_work = '{0, 1, 2, 3};
                i = N - 1 - m_cyc;
                j = (m_lfsr & 255) % (i + 1);
                t = m_work[i]; m_work[i] = m_work[j]; m_work[j] = t;
            end
            if (m_cyc == WIN - 1) begin
                m_prev_last = m_live ? m_cur[N-1] : -1;
                m_cur = m_work;
                m_live = 1;
                m_cyc = 0;
            end else begin
                m_cyc = m_cyc + 1;
            end
            m_lfsr = lfsr_step(m_lfsr);
        end
    end

    function automatic logic [7:0] exp_perm();
        logic [7:0] v;
        for (int s = 0; s < N; s++) v[2*s +: 2] = 2'(m_cur[s]);
        return v;
    endfunction

    function automatic logic [3:0] exp_grant();
        int owner;
        if (!m_live) return 4'h0;
        owner = m_cur[m_cyc / SC];
        return req[owner] ? 4'(1 << owner) : 4'h0;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit bad;
            bit b2b;
            bad = 0;
            b2b = m_live && (m_cyc < SC) && (m_prev_last == m_cur[0]);
            vectors++;
            if (perm_live !== m_live) begin
                bad = 1;
                $display("FAIL R4 perm_live actual %b expected %b at %0t", perm_live, m_live, $time);
            end
            if (perm_obs !== exp_perm()) begin
                bad = 1;
                $display("FAIL R7 perm_obs actual %h expected %h at %0t", perm_obs, exp_perm(), $time);
            end
            if (grant !== exp_grant()) begin
                bad = 1;
                $display("FAIL %s grant actual %b expected %b at %0t",
                         !m_live ? "R4" : (b2b ? "R8" : "R3"), grant, exp_grant(), $time);
            end
            if (bad) miscompares++;
            if (m_live && m_cyc == 0) begin
                bit ok;
                int cnt[4];
                cnt = '{0, 0, 0, 0};
                for (int s = 0; s < N; s++) cnt[perm_obs[2*s +: 2]]++;
                ok = (cnt[0] == 1) && (cnt[1] == 1) && (cnt[2] == 1) && (cnt[3] == 1);
                vectors++;
                if (!ok) begin
                    miscompares++;
                    $display("FAIL R2 not a permutation actual %h expected each id once", perm_obs);
                end
                seen[perm_obs] = 1;
                if (rec_on) rec_q.push_back(perm_obs);
                if (m_prev_last >= 0 && int'(perm_obs[1:0]) == m_prev_last) b2b_seen++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_seed(input logic [15:0] s);
        @(posedge clk); #1;
        seed_load = 1'b1; seed_value = s;
        @(posedge clk); #1;
        seed_load = 1'b0;
    endtask

    task automatic record(input logic [15:0] s, input int nw);
        load_seed(s);
        rec_q.delete();
        rec_on = 1;
        tick(WIN + nw * WIN);
        rec_on = 0;
    endtask

    task automatic compare_recs(input string tag);
        vectors++;
        if (rec_a.size() != rec_b.size() || rec_a.size() == 0) begin
            miscompares++;
            $display("FAIL %s record length actual %0d expected %0d", tag, rec_b.size(), rec_a.size());
        end else begin
            for (int k = 0; k < rec_a.size(); k++) begin
                if (rec_a[k] !== rec_b[k]) begin
                    miscompares++;
                    $display("FAIL %s window %0d order actual %h expected %h", tag, k, rec_b[k], rec_a[k]);
                    break;
                end
            end
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        tick(3);
        // R1: reset state, sampled while reset is held
        vectors++;
        if (grant !== 4'h0 || perm_live !== 1'b0 || perm_obs !== 8'hE4) begin
            miscompares++;
            $display("FAIL R1 reset actual grant %b live %b perm %h expected 0000 0 e4",
                     grant, perm_live, perm_obs);
        end
        rst_n = 1'b1;

        // R3 R8: every core requesting
        req = 4'hF;
        tick(40 * WIN);

        // R3: irregular request patterns
        for (int k = 0; k < 200 * WIN; k++) begin
            req = 4'($urandom);
            tick(1);
        end

        // R4: seed loaded mid-window, then priming
        req = 4'hF;
        tick(3);

        // R6: same seed replays the same orders
        record(16'h1234, 16);
        rec_a = rec_q;
        tick(5);
        record(16'h1234, 16);
        rec_b = rec_q;
        compare_recs("R6");

        // R5: zero seed behaves as the substitute seed
        record(16'h0000, 16);
        rec_a = rec_q;
        record(16'hACE1, 16);
        rec_b = rec_q;
        compare_recs("R5");

        // R9: long run collecting orderings
        for (int k = 0; k < 2500 * WIN; k++) begin
            req = 4'($urandom);
            tick(1);
        end

        begin
            int distinct;
            distinct = 0;
            for (int v = 0; v < 256; v++) if (seen[v]) distinct++;
            vectors++;
            if (distinct != 24) begin
                miscompares++;
                $display("FAIL R9 distinct orderings actual %0d expected 24", distinct);
            end
        end
        vectors++;
        if (b2b_seen == 0) begin
            miscompares++;
            $display("FAIL R8 back-to-back ownership actual %0d expected >0", b2b_seen);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual running expected finished");
            finish_run();
        end
    end

endmodule